// File: doc/BRIEF.md
# Timer/Event Counter with Pulse-Width Capture

This block is a programmable up-counter for a small controller. It has three ways of advancing. In event mode it counts the chosen edges of an external pin. In timer mode it steps once every four system clocks. In pulse mode it measures how long the external pin stays at a chosen level, with the same divide-by-four time base. A preload register is written over a simple write strobe. On every wrap the counter restarts from the preload value and raises a one-cycle interrupt pulse.

Software writes the preload value while the counter is stopped, which also seeds the count. It then writes the mode, run and edge fields together in one configuration write. In pulse mode the run bit clears itself when the measured pulse ends, and the result stays frozen until the next configuration write. The external pin passes through a two-flop synchronizer before any edge is detected, so the count lags a pin change by three clocks.

Top module: `tmr_capture_unit`

## Requirements
- R1: After reset the count, the preload register, the run bit, the mode (code 00) and the interrupt pulse are all zero.
- R2: With mode code 00, or with the run bit clear, the count does not change for any pin activity, except through a preload write.
- R3: A preload write while the counter is stopped (run bit clear or mode 00) loads the new value into the count on the same clock edge. A preload write while the counter is running changes only the preload register.
- R4: Mode code 10 (timer) adds one to the count on every fourth clock while the run bit is set. The first increment comes on the fourth clock edge after the run bit takes effect.
- R5: Mode code 01 (event) adds one per edge of the synchronized pin. The edge bit set to 1 selects rising edges and set to 0 selects falling edges. The count moves on the third clock edge after the pin changes.
- R6: When an increment finds the count at its all-ones value, the count reloads from the preload register. For that one clock only, the interrupt output is high.
- R7: Mode code 11 (pulse) arms on a transition of the synchronized pin toward the edge bit's level (1 means rising, 0 means falling). While the pin stays at that level the counter advances once per four clocks, counted from the arming edge.
- R8: In pulse mode, when the synchronized pin leaves the measured level, counting stops and the run bit clears on that clock edge. A configuration write in the same cycle takes precedence.
- R9: After a pulse measurement ends, later transitions of the pin leave the count unchanged until software writes the configuration again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfgWe | input | 1 | Configuration write strobe (mode, run, edge) |
| cfgMode | input | 2 | Mode: 00 stopped, 01 event, 10 timer, 11 pulse |
| cfgEnable | input | 1 | Run bit value to write |
| cfgEdge | input | 1 | Edge/level select: 1 rising/high, 0 falling/low |
| preloadWe | input | 1 | Preload register write strobe |
| preloadData | input | CNT_W | Preload value |
| evtPin | input | 1 | Asynchronous external event/pulse input |
| countValue | output | CNT_W | Current count |
| enableState | output | 1 | Current run bit (clears itself at the end of a pulse) |
| ovfPulse | output | 1 | One-cycle overflow interrupt request |

## Verification
The bench aims at the wrap with a preload close to all-ones. A design that reloaded from zero, or that held the interrupt high for more than one clock, would drift from the model there. Pulse measurements of lengths that are not multiples of four check the divide-by-four phase. Because the pin keeps toggling after a measurement, a design that re-armed or failed to drop its run bit would keep counting. Preload writes made while running, and pin activity while stopped or idle, would expose a count that was overwritten or moved when it should have held.

// File: rtl/tmr_cap_pkg.sv
package tmr_cap_pkg;

  typedef enum logic [1:0] {
    MODE_IDLE  = 2'b00,
    MODE_EVENT = 2'b01,
    MODE_TIMER = 2'b10,
    MODE_PULSE = 2'b11
  } tmrMode_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic incr;     // advance the count by one (or wrap)
    logic loadNow;  // copy the preload bus straight into the count
  } tmrStrobe_t;

endpackage

// File: rtl/tmr_cap_ctrl.sv
module tmr_cap_ctrl
  import tmr_cap_pkg::*;
#(
  parameter int PRESC_DIV   = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfgWe,
  input  logic [1:0] cfgMode,
  input  logic       cfgEnable,
  input  logic       cfgEdge,
  input  logic       preloadWe,
  input  logic       evtPin,
  output tmrStrobe_t strobe,
  output logic       enableState
);

  localparam int PRESC_W = (PRESC_DIV > 1) ? $clog2(PRESC_DIV) : 1;
  localparam logic [PRESC_W-1:0] PRESC_LAST = PRESC_W'(PRESC_DIV - 1);

  tmrMode_e modeReg;
  logic     enReg;
  logic     edgeReg;
  logic     measuring;

  // ---------------- pin synchronizer ----------------
  logic [SYNC_STAGES-1:0] syncPipe;
  logic                   pinPrev;
  logic                   pinNow;

  always_ff @(posedge clk) begin
    if (!rst_n) syncPipe[0] <= 1'b0;
    else        syncPipe[0] <= evtPin;
  end

  generate
    for (genvar s = 1; s < SYNC_STAGES; s++) begin : g_sync
      always_ff @(posedge clk) begin
        if (!rst_n) syncPipe[s] <= 1'b0;
        else        syncPipe[s] <= syncPipe[s-1];
      end
    end
  endgenerate

  assign pinNow = syncPipe[SYNC_STAGES-1];

  always_ff @(posedge clk) begin
    if (!rst_n) pinPrev <= 1'b0;
    else        pinPrev <= pinNow;
  end

  logic riseSeen, fallSeen, selEdge, atLevel;
  assign riseSeen = pinNow & ~pinPrev;
  assign fallSeen = ~pinNow & pinPrev;
  assign selEdge  = edgeReg ? riseSeen : fallSeen;
  assign atLevel  = (pinNow == edgeReg);

  // ---------------- mode decode ----------------
  logic running, pulseMode, startEdge, stopPulse, gate, tick;
  assign running   = enReg && (modeReg != MODE_IDLE);
  assign pulseMode = running && (modeReg == MODE_PULSE);
  assign startEdge = pulseMode && !measuring && selEdge;
  assign stopPulse = pulseMode && measuring && !atLevel;

  always_comb begin
    gate = 1'b0;
    if (running && modeReg == MODE_TIMER) gate = 1'b1;
    if (pulseMode && (startEdge || measuring) && atLevel) gate = 1'b1;
  end

  // ---------------- prescaler ----------------
  logic [PRESC_W-1:0] presc;

  always_ff @(posedge clk) begin
    if (!rst_n)             presc <= '0;
    else if (!gate)         presc <= '0;
    else if (presc == PRESC_LAST) presc <= '0;
    else                    presc <= presc + 1'b1;
  end

  assign tick = gate && (presc == PRESC_LAST);

  // ---------------- configuration state ----------------
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      modeReg   <= MODE_IDLE;
      enReg     <= 1'b0;
      edgeReg   <= 1'b0;
      measuring <= 1'b0;
    end else if (cfgWe) begin
      modeReg   <= tmrMode_e'(cfgMode);
      enReg     <= cfgEnable;
      edgeReg   <= cfgEdge;
      measuring <= 1'b0;
    end else if (startEdge) begin
      measuring <= 1'b1;
    end else if (stopPulse) begin
      measuring <= 1'b0;
      enReg     <= 1'b0;
    end
  end

  always_comb begin
    strobe.incr    = tick || (running && modeReg == MODE_EVENT && selEdge);
    strobe.loadNow = preloadWe && !running;
  end

  assign enableState = enReg;

  // ---------------- assertions ----------------
  a_r8_self_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (stopPulse && !cfgWe) |=> !enReg);

  a_r9_no_rearm: assert property (@(posedge clk) disable iff (!rst_n)
    (stopPulse && !cfgWe) |=> !measuring);

  a_r7_start_stop_excl: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({startEdge, stopPulse}));

  a_r4_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);

  a_r2_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !running |-> !strobe.incr);

endmodule

// File: rtl/tmr_cap_datapath.sv
module tmr_cap_datapath
  import tmr_cap_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  tmrStrobe_t       strobe,
  input  logic             preloadWe,
  input  logic [CNT_W-1:0] preloadData,
  output logic [CNT_W-1:0] countValue,
  output logic             ovfPulse
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] preloadReg;
  logic [CNT_W-1:0] countReg;
  logic             ovfReg;

  always_ff @(posedge clk) begin
    if (!rst_n)         preloadReg <= '0;
    else if (preloadWe) preloadReg <= preloadData;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      countReg <= '0;
      ovfReg   <= 1'b0;
    end else begin
      ovfReg <= 1'b0;
      if (strobe.loadNow) begin
        countReg <= preloadData;
      end else if (strobe.incr) begin
        if (countReg == CNT_MAX) begin
          countReg <= preloadReg;
          ovfReg   <= 1'b1;
        end else begin
          countReg <= countReg + 1'b1;
        end
      end
    end
  end

  assign countValue = countReg;
  assign ovfPulse   = ovfReg;

  // ---------------- assertions ----------------
  a_r6_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    ovfPulse |=> !ovfPulse);

  a_r6_reload: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.incr && countReg == CNT_MAX) |=> (ovfPulse && countValue == $past(preloadReg)));

  a_r4_step: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.incr && !strobe.loadNow && countReg != CNT_MAX) |=> countValue == $past(countReg) + 1'b1);

  a_r3_excl: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({strobe.incr, strobe.loadNow}));

  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!strobe.incr && !strobe.loadNow) |=> $stable(countValue));

endmodule

// File: rtl/tmr_capture_unit.sv
module tmr_capture_unit
  import tmr_cap_pkg::*;
#(
  parameter int CNT_W     = 16,
  parameter int PRESC_DIV = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfgWe,
  input  logic [1:0]       cfgMode,
  input  logic             cfgEnable,
  input  logic             cfgEdge,
  input  logic             preloadWe,
  input  logic [CNT_W-1:0] preloadData,
  input  logic             evtPin,
  output logic [CNT_W-1:0] countValue,
  output logic             enableState,
  output logic             ovfPulse
);

  tmrStrobe_t strobe;

  tmr_cap_ctrl #(
    .PRESC_DIV  (PRESC_DIV),
    .SYNC_STAGES(2)
  ) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfgWe      (cfgWe),
    .cfgMode    (cfgMode),
    .cfgEnable  (cfgEnable),
    .cfgEdge    (cfgEdge),
    .preloadWe  (preloadWe),
    .evtPin     (evtPin),
    .strobe     (strobe),
    .enableState(enableState)
  );

  tmr_cap_datapath #(
    .CNT_W(CNT_W)
  ) u_dp (
    .clk        (clk),
    .rst_n      (rst_n),
    .strobe     (strobe),
    .preloadWe  (preloadWe),
    .preloadData(preloadData),
    .countValue (countValue),
    .ovfPulse   (ovfPulse)
  );

  a_r1_reset_clear: assert property (@(posedge clk)
    !rst_n |=> (countValue == '0 && !enableState && !ovfPulse));

endmodule

// File: tb/tmr_capture_unit_bench.sv
`timescale 1ns/1ps
module tmr_capture_unit_bench;

  localparam int W   = 8;
  localparam int MAXV = (1 << W) - 1;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         cfgWe = 1'b0;
  logic [1:0]   cfgMode = 2'b00;
  logic         cfgEnable = 1'b0;
  logic         cfgEdge = 1'b0;
  logic         preloadWe = 1'b0;
  logic [W-1:0] preloadData = '0;
  logic         evtPin = 1'b0;
  logic [W-1:0] countValue;
  logic         enableState;
  logic         ovfPulse;

  always #4 clk = ~clk;

  tmr_capture_unit #(.CNT_W(W), .PRESC_DIV(4)) u_tmr_capture_unit (
    .clk(clk), .rst_n(rst_n), .cfgWe(cfgWe), .cfgMode(cfgMode),
    .cfgEnable(cfgEnable), .cfgEdge(cfgEdge), .preloadWe(preloadWe),
    .preloadData(preloadData), .evtPin(evtPin), .countValue(countValue),
    .enableState(enableState), .ovfPulse(ovfPulse)
  );

  int vectors = 0;
  int miscompares = 0;
  string phase = "R1";
  bit done = 0;

  // ---------------- behavioural reference ----------------
  int mCount, mPre, mMode, mPresc, mOvfTotal, dutOvfTotal;
  bit mEn, mEdge, mMeas, mOvf, mS1, mS2, mPrev;
  bit rise, fall, sel, lvl, run, inc, gate, start, stop;

  always @(posedge clk) begin
    if (!rst_n) begin
      mCount = 0; mPre = 0; mMode = 0; mPresc = 0;
      mEn = 0; mEdge = 0; mMeas = 0; mOvf = 0;
      mS1 = 0; mS2 = 0; mPrev = 0;
    end else begin
      rise = mS2 && !mPrev;
      fall = !mS2 && mPrev;
      sel  = mEdge ? rise : fall;
      lvl  = (mS2 == mEdge);
      run  = mEn && (mMode != 0);
      inc = 0; gate = 0; start = 0; stop = 0;
      case (mMode)
        1: inc = run && sel;
        2: gate = run;
        3: begin
             start = run && !mMeas && sel;
             stop  = run && mMeas && !lvl;
             gate  = run && (start || mMeas) && lvl;
           end
        default: ;
      endcase
      if (gate) begin
        if (mPresc == 3) begin inc = 1; mPresc = 0; end
        else mPresc++;
      end else mPresc = 0;
      mOvf = 0;
      if (preloadWe && !run) mCount = preloadData;
      else if (inc) begin
        if (mCount == MAXV) begin mCount = mPre; mOvf = 1; mOvfTotal++; end
        else mCount++;
      end
      if (preloadWe) mPre = preloadData;
      if (cfgWe) begin
        mMode = cfgMode; mEn = cfgEnable; mEdge = cfgEdge; mMeas = 0;
      end else begin
        if (start) mMeas = 1;
        if (stop) begin mMeas = 0; mEn = 0; end
      end
      mPrev = mS2; mS2 = mS1; mS1 = evtPin;
    end
  end

  task automatic chk(string req, int act, int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // cycle-by-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk({phase, " count"},  countValue,  mCount);
      chk({phase, " enable"}, enableState, mEn);
      chk({phase, " ovf"},    ovfPulse,    mOvf);
      if (ovfPulse) dutOvfTotal++;
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic writeCfg(logic [1:0] m, logic en, logic ed);
    @(negedge clk);
    cfgWe = 1; cfgMode = m; cfgEnable = en; cfgEdge = ed;
    @(negedge clk);
    cfgWe = 0;
  endtask

  task automatic writePre(int v);
    @(negedge clk);
    preloadWe = 1; preloadData = W'(v);
    @(negedge clk);
    preloadWe = 0;
  endtask

  task automatic pinFor(logic v, int n);
    evtPin = v;
    idle(n);
  endtask

  int held;

  initial begin
    mOvfTotal = 0; dutOvfTotal = 0;
    idle(3);
    rst_n = 1;
    @(negedge clk);
    // R1: reset state
    chk("R1 count", countValue, 0);
    chk("R1 enable", enableState, 0);
    chk("R1 ovf", ovfPulse, 0);

    // R3: preload while stopped seeds count
    phase = "R3";
    writePre(8'h10);
    chk("R3 seeded", countValue, 8'h10);

    // R2: idle mode ignores pin activity
    phase = "R2";
    for (int i = 0; i < 6; i++) pinFor(i[0], 3);
    idle(4);
    chk("R2 held idle", countValue, 8'h10);

    // R4: timer mode
    phase = "R4";
    writeCfg(2'b10, 1, 0);
    idle(41);
    // R3: preload while running leaves count alone
    phase = "R3";
    held = countValue;
    writePre(8'hFC);
    chk("R3 running write", countValue, held);

    // R6: wrap reloads preload and pulses
    phase = "R6";
    idle(1200);
    chk("R6 ovf count", dutOvfTotal, mOvfTotal);
    chk("R6 wraps seen", int'(mOvfTotal > 3), 1);

    // R2: run bit clear in event mode
    phase = "R2";
    writeCfg(2'b01, 0, 1);
    held = countValue;
    for (int i = 0; i < 8; i++) pinFor(i[0], 2);
    idle(4);
    chk("R2 held disabled", countValue, held);

    // R5: event mode, rising then falling, various spacings
    phase = "R5";
    writePre(8'hF0);
    writeCfg(2'b01, 1, 1);
    for (int i = 0; i < 40; i++) pinFor(~evtPin, 1 + (i % 3));
    idle(6);
    writeCfg(2'b01, 1, 0);
    for (int i = 0; i < 40; i++) pinFor(~evtPin, 2 + (i % 2));
    idle(6);

    // R7/R8/R9: pulse mode, high level
    phase = "R7";
    writeCfg(2'b00, 0, 0);
    pinFor(0, 5);
    writePre(8'h00);
    writeCfg(2'b11, 1, 1);
    pinFor(0, 4);
    pinFor(1, 23);
    phase = "R8";
    pinFor(0, 6);
    chk("R8 run cleared", enableState, 0);
    chk("R7 width 23", countValue, 5);
    phase = "R9";
    held = countValue;
    for (int i = 0; i < 10; i++) pinFor(~evtPin, 5);
    pinFor(0, 6);
    chk("R9 result held", countValue, held);

    // R7/R8: pulse mode, low level, pin starts high
    phase = "R7";
    pinFor(1, 5);
    writePre(8'hFE);
    writeCfg(2'b11, 1, 0);
    pinFor(1, 3);
    pinFor(0, 37);
    phase = "R8";
    pinFor(1, 6);
    chk("R8 run cleared low", enableState, 0);
    phase = "R9";
    for (int i = 0; i < 6; i++) pinFor(~evtPin, 4);
    idle(6);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  // watchdog
  initial begin
    #(8 * 150000);
    miscompares++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule